// File: doc/BRIEF.md
# Master clock ratio detector

This block runs in the master-clock domain of an audio DAC. It measures how many master-clock cycles pass between rising edges of the frame (left/right) signal and treats each count as one sample period. Each period is compared against the supported master-clock to sample-rate ratios. The block reports which ratio matched, the sample-speed mode that follows from it, and a lock flag. When no valid ratio is locked, it raises an automatic mute. The frame signal is asynchronous to the master clock, so it passes through a two-flop synchronizer before edge detection.

In auto mode the ratio decides the speed mode on its own. In programmable mode a 4-bit setting fixes the expected ratio and the speed. Every measured period is still compared against that expected ratio, and a mismatch mutes the output. The setting can reach combinations that auto mode never produces, such as 256 or 384 times the rate at quad speed.

Top module: `mclk_ratio_detect`

## Requirements
- R1: `ratio_code` encodes the locked ratio as 0=64, 1=96, 2=128, 3=192, 4=256 and 5=384 master clocks per sample. It reads 7 whenever `locked` is low.
- R2: A period count equals the number of master-clock cycles between two synchronized frame rising edges. The count matches a ratio when it lies within the ratio ±8, inclusive. A count that is 9 away from every ratio matches none.
- R3: In auto mode, `speed` is 0 (1X) for ratios 256 and 384, 1 (2X) for 128 and 192, and 2 (4X) for 64 and 96. `speed` reads 3 when not locked.
- R4: `locked` rises only after two consecutive periods match the same ratio and speed. The first frame edge after reset or after a timeout only starts the measurement.
- R5: A single period that matches nothing clears `locked` at once. After that, lock returns only after two new matching periods.
- R6: If no synchronized frame rising edge arrives for 512 master-clock cycles, `locked` drops and the next edge restarts the measurement.
- R7: `auto_mute` is high exactly when `locked` is low, and it is high after reset.
- R8: In programmable mode, `prog_cfg[0]` selects the 1.5x variant of a base ratio. `prog_cfg[3:1]` selects the base ratio and speed as follows: 0 = 256 at 1X, 1 = 128 at 2X, 2 = 256 at 2X, 3 = 64 at 4X, 4 = 128 at 4X, 5 = 256 at 4X. Values 6 and 7 never lock.
- R9: In programmable mode, a period that lies outside ±8 of the configured ratio counts as a mismatch and keeps or forces `locked` low, even when it matches another supported ratio.
- R10: `locked` changes only in the cycle after a synchronized frame edge is detected, or in the cycle after a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_in | input | 1 | Frame signal, asynchronous to clk |
| prog_mode | input | 1 | 1 = programmable mode, 0 = auto mode |
| prog_cfg | input | 4 | Ratio and speed setting for programmable mode |
| ratio_code | output | 3 | Locked ratio code, 7 when unlocked |
| speed | output | 2 | Speed mode 0=1X, 1=2X, 2=4X, 3 when unlocked |
| locked | output | 1 | Ratio lock flag |
| auto_mute | output | 1 | Mute request |

## Verification
Each frame rising edge takes three clk edges to reach the lock state: two synchronizer stages and one edge-detect stage. Every output therefore settles a few cycles after the rise that closes a period. The bench drives whole periods of at least 55 cycles and samples on the falling clock edge at the end of a period, well after that latency. Timeout checks wait 600 idle cycles, so the 512-cycle limit has passed without any sampling near the boundary. Window tests use offsets of ±8 and ±9 for every ratio, and each test first clears any earlier lock with an idle gap.

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect #(
  parameter int TOL     = 8,
  parameter int TIMEOUT = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_in,
  input  logic       prog_mode,
  input  logic [3:0] prog_cfg,
  output logic [2:0] ratio_code,
  output logic [1:0] speed,
  output logic       locked,
  output logic       auto_mute
);
  localparam int CW = $clog2(TIMEOUT + 1) + 1;

  function automatic logic [CW-1:0] ratio_of(input logic [2:0] c);
    logic [CW-1:0] base;
    base = CW'(64) << c[2:1];
    return c[0] ? base + (base >> 1) : base;
  endfunction

  function automatic logic near(input logic [CW-1:0] m, input logic [CW-1:0] r);
    return (m + CW'(TOL) >= r) && (m <= r + CW'(TOL));
  endfunction

  logic [2:0] sync_q;
  logic [CW-1:0] cnt;
  logic seen, prev_ok, lock_q;
  logic [4:0] prev_tag;
  logic [2:0] code_q;
  logic [1:0] spd_q;

  wire frm_rise = sync_q[1] & ~sync_q[2];
  wire tmo_hit  = ~frm_rise & (cnt == CW'(TIMEOUT));

  logic       auto_hit;
  logic [2:0] auto_code;
  always_comb begin
    auto_hit  = 1'b0;
    auto_code = 3'd0;
    for (int c = 0; c < 6; c++)
      if (near(cnt, ratio_of(3'(c)))) begin
        auto_hit  = 1'b1;
        auto_code = 3'(c);
      end
  end

  logic [1:0] p_base, p_spd;
  logic       p_valid;
  always_comb begin
    p_valid = 1'b1;
    unique case (prog_cfg[3:1])
      3'd0:    begin p_base = 2'd2; p_spd = 2'd0; end
      3'd1:    begin p_base = 2'd1; p_spd = 2'd1; end
      3'd2:    begin p_base = 2'd2; p_spd = 2'd1; end
      3'd3:    begin p_base = 2'd0; p_spd = 2'd2; end
      3'd4:    begin p_base = 2'd1; p_spd = 2'd2; end
      3'd5:    begin p_base = 2'd2; p_spd = 2'd2; end
      default: begin p_base = 2'd0; p_spd = 2'd3; p_valid = 1'b0; end
    endcase
  end
  wire [2:0] p_code = {p_base, prog_cfg[0]};

  wire       hit     = prog_mode ? (p_valid && near(cnt, ratio_of(p_code))) : auto_hit;
  wire [2:0] sel_code = prog_mode ? p_code : auto_code;
  wire [1:0] sel_spd  = prog_mode ? p_spd : 2'd2 - sel_code[2:1];
  wire [4:0] sel_tag  = {sel_code, sel_spd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      cnt      <= '0;
      seen     <= 1'b0;
      prev_ok  <= 1'b0;
      prev_tag <= '0;
      lock_q   <= 1'b0;
      code_q   <= '0;
      spd_q    <= '0;
    end else begin
      sync_q <= {sync_q[1:0], frame_in};
      if (frm_rise) begin
        cnt  <= CW'(1);
        seen <= 1'b1;
        if (!seen) begin
          prev_ok <= 1'b0;
          lock_q  <= 1'b0;
        end else if (hit) begin
          lock_q   <= prev_ok && (prev_tag == sel_tag);
          prev_ok  <= 1'b1;
          prev_tag <= sel_tag;
          code_q   <= sel_code;
          spd_q    <= sel_spd;
        end else begin
          prev_ok <= 1'b0;
          lock_q  <= 1'b0;
        end
      end else if (tmo_hit) begin
        seen    <= 1'b0;
        prev_ok <= 1'b0;
        lock_q  <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign locked     = lock_q;
  assign auto_mute  = ~lock_q;
  assign ratio_code = lock_q ? code_q : 3'd7;
  assign speed      = lock_q ? spd_q : 2'd3;
endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_mode,
  input logic [2:0] ratio_code,
  input logic [1:0] speed,
  input logic       locked,
  input logic       auto_mute,
  input logic       edge_p,
  input logic       tmo_p
);
  a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (ratio_code <= 3'd5) && (speed <= 2'd2));

  a_r3_auto_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !prog_mode) |-> (speed == 2'd2 - ratio_code[2:1]));

  a_r7_unlocked_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (ratio_code == 3'd7) && (speed == 2'd3) && auto_mute);

  a_r6_timeout_drop: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_p |=> !locked);

  a_r10_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(edge_p));

  a_r10_fall_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(edge_p) || $past(tmo_p)));
endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .ratio_code(ratio_code),
  .speed(speed), .locked(locked), .auto_mute(auto_mute),
  .edge_p(frm_rise), .tmo_p(tmo_hit)
);

// File: tb/mclk_ratio_detect_test.sv
module mclk_ratio_detect_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, frame_in = 1'b0, prog_mode = 1'b0;
  logic [3:0] prog_cfg = 4'd0;
  logic [2:0] ratio_code;
  logic [1:0] speed;
  logic locked, auto_mute;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mclk_ratio_detect uut (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .prog_mode(prog_mode),
    .prog_cfg(prog_cfg), .ratio_code(ratio_code), .speed(speed),
    .locked(locked), .auto_mute(auto_mute)
  );

  function automatic int ratio_val(int c);
    return (64 << (c / 2)) * ((c % 2) ? 3 : 2) / 2;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic period(int n);
    @(negedge clk) frame_in = 1'b1;
    repeat (n / 2 - 1) @(negedge clk);
    frame_in = 1'b0;
    repeat (n - n / 2) @(negedge clk);
  endtask

  task automatic idle();
    frame_in = 1'b0;
    repeat (600) @(negedge clk);
  endtask

  task automatic expect_state(string req, bit lk, int code, int spd);
    check(req, locked, lk);
    check(req, auto_mute, !lk);
    check(req, ratio_code, lk ? code : 7);
    check(req, speed, lk ? spd : 3);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_state("R7 reset", 0, 7, 3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_state("R7 after reset", 0, 7, 3);

    // R1 R2 R3 R4: auto sweep over every ratio with window offsets
    for (int c = 0; c < 6; c++) begin
      for (int k = 0; k < 5; k++) begin
        int off, n;
        bit ok;
        off = (k == 0) ? 0 : (k == 1) ? -8 : (k == 2) ? 8 : (k == 3) ? -9 : 9;
        n = ratio_val(c) + off;
        ok = (off >= -8 && off <= 8);
        idle();
        period(n);
        period(n);
        expect_state("R4 one measure", 0, 7, 3);
        period(n);
        expect_state(ok ? "R2 R1 R3 window hit" : "R2 window miss", ok, c, 2 - c / 2);
      end
    end

    // R5: one bad period drops lock, two good ones restore it
    idle();
    repeat (3) period(256);
    expect_state("R5 locked", 1, 4, 0);
    period(300);
    expect_state("R5 bad not yet seen", 1, 4, 0);
    period(256);
    expect_state("R5 mismatch drop", 0, 7, 3);
    period(256);
    expect_state("R5 one good after drop", 0, 7, 3);
    period(256);
    expect_state("R5 relock", 1, 4, 0);
    period(192);
    period(192);
    expect_state("R4 ratio change", 0, 7, 3);
    period(192);
    expect_state("R4 new ratio lock", 1, 3, 1);

    // R6: no frame edge for over 512 cycles
    idle();
    expect_state("R6 timeout", 0, 7, 3);
    period(128);
    period(128);
    expect_state("R6 restart", 0, 7, 3);

    // R8: programmable sweep over all settings
    idle();
    prog_mode = 1'b1;
    for (int cfg = 0; cfg < 16; cfg++) begin
      int sel, base, spd, code, n;
      bit valid;
      sel = cfg >> 1;
      valid = sel <= 5;
      base = (sel == 0 || sel == 2 || sel == 5) ? 2 : (sel == 1 || sel == 4) ? 1 : 0;
      spd = (sel == 0) ? 0 : (sel <= 2) ? 1 : 2;
      code = base * 2 + (cfg & 1);
      n = valid ? ratio_val(code) : 256;
      prog_cfg = 4'(cfg);
      idle();
      repeat (3) period(n);
      expect_state("R8 prog setting", valid, code, spd);
    end

    // R9: programmable mismatch against a different supported ratio
    prog_cfg = 4'b1010;
    idle();
    repeat (3) period(128);
    expect_state("R9 prog mismatch", 0, 7, 3);
    repeat (3) period(264);
    expect_state("R9 prog match edge", 1, 4, 2);
    period(137);
    period(128);
    expect_state("R9 prog drop", 0, 7, 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule